// File: doc/BRIEF.md
# Video Presence Watchdog with Local Fallback

This block decides whether a locally generated video signal should drive the output, based on the amplitude of an external video input. A converter outside the block delivers 8-bit amplitude samples, each marked by a valid strobe. A sample whose value is above a fixed threshold means that an external source is present. When that happens, the block turns off the local generator and opens the switch that carries local video to the output.

A retriggerable silence timer covers the other direction. Each qualifying sample restarts it. The timer counts a prescaled clock and expires after a fixed number of prescaled ticks. At the default settings this comes to 256 × 256 clock cycles, which is about 3.3 ms, or roughly fifty video lines, at 20 MHz. When the timer expires, the block enables the local generator and closes the switch. The two controls come from one registered source selection, so they always change together. After reset, local video stays off until the first timeout, because external video is assumed to be present until silence proves otherwise.

Top module: `video_presence_watchdog`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `gen_enable` and `local_switch_on` are 0. The silence timer restarts from zero on the reset edge.
- R2: A sample qualifies only when `smp_valid` is 1 and `smp_data` is strictly greater than THRESHOLD (default 20). A valid sample equal to THRESHOLD does not qualify.
- R3: When `smp_valid` is 0, the value on `smp_data` has no effect on the outputs or on the timer, even at 255.
- R4: A qualifying sample drives both outputs to 0 on the next clock edge and restarts the silence timer from zero.
- R5: If no qualifying sample and no reset occurs for PRESCALE × TIMEOUT_TICKS consecutive edges after the last clearing edge, both outputs become 1 on exactly that edge and not earlier.
- R6: `gen_enable` and `local_switch_on` are equal on every cycle.
- R7: If a qualifying sample arrives on the same edge at which the timer would expire, the sample wins and both outputs are 0.
- R8: Once asserted, the outputs stay at 1 until a qualifying sample or a reset arrives. Further expiries of the timer change nothing.
- R9: Non-qualifying valid samples (at or below THRESHOLD) do not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks `smp_data` as a new amplitude sample |
| smp_data | input | SAMPLE_W (8) | Sampled amplitude of the external video |
| gen_enable | output | 1 | Enables the local video generator |
| local_switch_on | output | 1 | Closes the switch that passes local video to the output |

## Verification
The bench builds the block with PRESCALE = 4 and TIMEOUT_TICKS = 8, which shortens the silence window to 32 cycles. With the default window of 65 536 cycles a run could show only a handful of expiries. The short window lets one run reach the exact expiry edge many times. It also reaches a qualifying sample landing on that same edge, repeated expiries while the outputs are already on, and long runs of at-threshold samples that must not restart the timer. THRESHOLD stays at its default of 20, so the boundary between 20 and 21 is tested at its real value.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    // Which source owns the video output.
    typedef enum logic {
        SRC_EXTERNAL = 1'b0,
        SRC_LOCAL    = 1'b1
    } src_sel_e;

    // Control pair sent to the generator and to the analog switch.
    typedef struct packed {
        logic gen_en;
        logic sw_on;
    } route_t;

    localparam route_t ROUTE_OFF = '{gen_en: 1'b0, sw_on: 1'b0};
    localparam route_t ROUTE_ON  = '{gen_en: 1'b1, sw_on: 1'b1};

    function automatic route_t route_for(input src_sel_e sel);
        return (sel == SRC_LOCAL) ? ROUTE_ON : ROUTE_OFF;
    endfunction

    // Next owner: presence beats expiry, expiry beats hold.
    function automatic src_sel_e next_src(input src_sel_e cur,
                                          input logic     present,
                                          input logic     expired);
        if (present)      return SRC_EXTERNAL;
        else if (expired) return SRC_LOCAL;
        else              return cur;
    endfunction

endpackage

// File: rtl/vpw_detect.sv
module vpw_detect #(
    parameter int SAMPLE_W  = 8,
    parameter int THRESHOLD = 20
) (
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                present
);
    localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(THRESHOLD);

    always_comb begin
        present = smp_valid && (smp_data > THR);
    end
endmodule

// File: rtl/vpw_prescaler.sv
module vpw_prescaler #(
    parameter int PRESCALE = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || clear)      div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end
            always_comb tick = (div_q == LAST) && !clear;
        end else begin : g_pass
            always_comb tick = !clear;
        end
    endgenerate
endmodule

// File: rtl/vpw_timeout.sv
module vpw_timeout #(
    parameter int TIMEOUT_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

    logic [TW-1:0] cnt_q;
    logic          at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        expire  = tick && at_last && !clear;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt_q <= '0;
        else if (tick) begin
            if (at_last)   cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/video_presence_watchdog.sv
module video_presence_watchdog
    import vpw_pkg::*;
#(
    parameter int SAMPLE_W      = 8,
    parameter int THRESHOLD     = 20,
    parameter int PRESCALE      = 256,
    parameter int TIMEOUT_TICKS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                gen_enable,
    output logic                local_switch_on
);
    logic     present;
    logic     tick;
    logic     expire;
    src_sel_e src_q;
    route_t   route;

    vpw_detect #(
        .SAMPLE_W  (SAMPLE_W),
        .THRESHOLD (THRESHOLD)
    ) u_detect (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .present   (present)
    );

    vpw_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_prescale (
        .clk   (clk),
        .rst   (rst),
        .clear (present),
        .tick  (tick)
    );

    vpw_timeout #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timeout (
        .clk    (clk),
        .rst    (rst),
        .clear  (present),
        .tick   (tick),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_EXTERNAL;
        else     src_q <= next_src(src_q, present, expire);
    end

    always_comb begin
        route           = route_for(src_q);
        gen_enable      = route.gen_en;
        local_switch_on = route.sw_on;
    end
endmodule

// File: rtl/vpw_checker.sv
module vpw_checker #(
    parameter int SAMPLE_W      = 8,
    parameter int THRESHOLD     = 20,
    parameter int PRESCALE      = 256,
    parameter int TIMEOUT_TICKS = 256
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                gen_enable,
    input logic                local_switch_on
);
    localparam int LIMIT = PRESCALE * TIMEOUT_TICKS;
    localparam int QW    = $clog2(LIMIT + 1) + 1;

    logic          hit;
    logic [QW-1:0] quiet_q = '0;
    logic          prev_rst_q = 1'b0;

    assign hit = smp_valid && (smp_data > SAMPLE_W'(THRESHOLD));

    // Cycles since the last reset or qualifying sample, saturating.
    always_ff @(posedge clk) begin
        if (rst || hit)                    quiet_q <= '0;
        else if (quiet_q != {QW{1'b1}})    quiet_q <= quiet_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (prev_rst_q) begin
            assert_reset_off_R1: assert (!gen_enable && !local_switch_on)
                else $error("R1: outputs not off after reset");
        end
    end

    assert_pair_equal_R6: assert property (@(posedge clk) disable iff (rst)
        gen_enable == local_switch_on);

    assert_hit_turns_off_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (!gen_enable && !local_switch_on));

    assert_rise_after_silence_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_enable) |-> (quiet_q == QW'(LIMIT)));

    assert_stays_on_R8: assert property (@(posedge clk) disable iff (rst)
        (gen_enable && !hit) |=> gen_enable);
endmodule

bind video_presence_watchdog vpw_checker #(
    .SAMPLE_W      (SAMPLE_W),
    .THRESHOLD     (THRESHOLD),
    .PRESCALE      (PRESCALE),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .smp_valid       (smp_valid),
    .smp_data        (smp_data),
    .gen_enable      (gen_enable),
    .local_switch_on (local_switch_on)
);

// File: tb/video_presence_watchdog_tb.sv
module video_presence_watchdog_tb;
    localparam int SW    = 8;
    localparam int THR   = 20;
    localparam int PRE   = 4;
    localparam int TICKS = 8;
    localparam int LIMIT = PRE * TICKS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          gen_enable;
    logic          local_switch_on;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int m_since = 0;
    bit m_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    video_presence_watchdog #(
        .SAMPLE_W(SW), .THRESHOLD(THR), .PRESCALE(PRE), .TIMEOUT_TICKS(TICKS)
    ) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .gen_enable(gen_enable), .local_switch_on(local_switch_on)
    );

    function automatic bit qualifies(bit v, logic [SW-1:0] d);
        return v && (int'(d) > THR);
    endfunction

    task automatic check(string req, bit exp);
        checks++;
        if (gen_enable !== exp || local_switch_on !== exp) begin
            fails++;
            $display("FAIL %s: gen_enable=%0b local_switch_on=%0b expected %0b",
                     req, gen_enable, local_switch_on, exp);
        end
    endtask

    // Called at a negedge: apply inputs, advance the model, check at next negedge.
    task automatic cyc(bit v, logic [SW-1:0] d, string req);
        smp_valid = v;
        smp_data  = d;
        if (qualifies(v, d)) begin
            m_since = 0;
            m_on    = 1'b0;
        end else begin
            m_since++;
            if (m_since == LIMIT) begin
                m_since = 0;
                m_on    = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, m_on);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        smp_data = '0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst = 1'b0;
        m_since = 0;
        m_on = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        // R1: quiet after reset, off until first timeout; R5 exact edge
        for (int i = 0; i < LIMIT - 1; i++) cyc(1'b0, 8'd0, "R1");
        cyc(1'b0, 8'd0, "R5");
        // R8: stays on across several expiries
        for (int i = 0; i < 3 * LIMIT; i++) cyc(1'b1, 8'd5, "R8");
        // R2: value equal to threshold does not qualify
        cyc(1'b1, 8'd20, "R2");
        // R3: invalid large sample ignored
        cyc(1'b0, 8'd255, "R3");
        // R2/R4: value just above threshold turns outputs off
        cyc(1'b1, 8'd21, "R4");
        // R9: at-threshold samples do not re-arm; R5 expiry exact
        for (int i = 0; i < LIMIT - 1; i++) cyc(1'b1, 8'd20, "R9");
        cyc(1'b1, 8'd20, "R5");
        // R4: hit then R3 invalid big samples during silence do not re-arm
        cyc(1'b1, 8'd255, "R4");
        for (int i = 0; i < LIMIT - 1; i++) cyc(1'b0, 8'd200, "R3");
        // R7: hit on expiry edge wins
        cyc(1'b1, 8'd100, "R7");
        for (int i = 0; i < LIMIT - 1; i++) cyc(1'b0, 8'd0, "R7");
        cyc(1'b1, 8'd22, "R7");
        // R1: reset mid-run while on
        for (int i = 0; i < LIMIT; i++) cyc(1'b0, 8'd0, "R5");
        do_reset();
        cyc(1'b0, 8'd0, "R1");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit v;
            logic [SW-1:0] d;
            string tag;
            r = int'($urandom % 100);
            if (r < 3) begin
                v = 1'b1;
                d = SW'(21 + ($urandom % 235));
            end else begin
                v = 1'($urandom % 2);
                d = v ? SW'($urandom % 21) : SW'($urandom);
            end
            if (qualifies(v, d))          tag = "R4";
            else if (m_since == LIMIT - 1) tag = "R5";
            else if (m_on)                 tag = "R8";
            else                           tag = "R9";
            cyc(v, d, tag);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule